// File: doc/BRIEF.md
# Dot-Clock LCD Sync and Window Timing Generator

This block produces the line sync, frame sync, data-enable and pixel-request strobes for a parallel RGB panel driven by a dot clock. Every timing quantity is a live input, normally driven from configuration registers elsewhere in the chip. The horizontal counter runs in pixel clocks and the vertical counter in lines. Both counters start at the leading edge of their sync pulse. The active window on each axis opens after a wait count measured from that point and stays open for a programmed number of pixels or lines.

Software writes an upcoming frame base address at any time. The block copies it into the current-base output at the first pixel of every frame, so a new buffer never appears mid-frame. A sync-enable input starts the counters and outputs. A separate run input decides, once per frame, whether pixel requests are issued, so a frame that has begun is always fetched to its end. Polarity inputs set the active level of each strobe. A pixel-clock edge select is captured only while timing is stopped.

Top module: `lcd_dotclk_timing`

## Requirements
- R1: While `sync_en` is low, both position counters are held at 0, and from the next clock edge `hsync`, `vsync` and `de` sit at their inactive levels and `pix_req` is 0.
- R2: With `sync_en` high, the pixel position counts 0 to `line_period`-1 and then wraps. `hsync` is active while the position is below `hsync_width`. Outputs show the position of the previous cycle, so the first edge with `sync_en` high drives position 0.
- R3: The line position advances when the pixel position wraps, counts 0 to `frame_period`-1 and then wraps. `vsync` is active while the line position is below `vsync_width`.
- R4: The pixel is in the active window when `h_wait` <= pixel position < `h_wait`+`h_pixels` and `v_wait` <= line position < `v_wait`+`v_lines`. `de` is active only then.
- R5: `hs_high`, `vs_high` and `de_high` set 1 as the active level of their strobe; 0 makes that strobe active-low.
- R6: Reset drives `hsync`, `vsync`, `de`, `pix_req`, `pclk_invert` and `cur_base` to 0.
- R7: At the first pixel of every frame (pixel 0 and line 0, including the first frame after enabling), `cur_base` takes the value of `next_base`. It is unchanged at every other time.
- R8: `run` is sampled at the first pixel of each frame. `pix_req` is 1 for a pixel in the active window of a frame that began with `run` high. Clearing `run` mid-frame does not stop requests before the next frame.
- R9: `pclk_invert` follows `pclk_fall` only while `sync_en` is low and holds its value while timing runs.
- R10: A `line_period` or `frame_period` of 0 or 1 makes that counter wrap on every step.
- R11: The `hsync_width` field width is a parameter (14 bits wide, or 8 bits for the narrow variant). Its full range produces that many active clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_en | input | 1 | Starts counters and sync outputs |
| run | input | 1 | Allows pixel requests, sampled per frame |
| line_period | input | H_W | Pixel clocks per line |
| hsync_width | input | HSW_W | Line sync width in pixel clocks |
| h_wait | input | HWAIT_W | Sync start to first active pixel |
| h_pixels | input | H_W | Valid pixels per line |
| frame_period | input | V_W | Lines per frame |
| vsync_width | input | V_W | Frame sync width in lines |
| v_wait | input | VWAIT_W | Sync start to first active line |
| v_lines | input | VWAIT_W | Active lines per frame |
| hs_high | input | 1 | Line sync active high |
| vs_high | input | 1 | Frame sync active high |
| de_high | input | 1 | Data enable active high |
| pclk_fall | input | 1 | Falling pixel-clock edge is active |
| next_base | input | ADDR_W | Upcoming frame base address |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Pixel data request |
| cur_base | output | ADDR_W | Base address of the frame being scanned |
| pclk_invert | output | 1 | Captured pixel-clock edge select |

## Verification
The bench builds the block with the narrow 8-bit line-sync width field and default widths elsewhere. Small programmed periods of up to a few dozen clocks keep whole frames short. Many random configurations therefore complete several frames each, which exercises wraps, frame-start base swaps and run sampling at frame boundaries many times. The 8-bit field allows a directed run at its full value of 255. Periods of 0 and 1 are driven to reach the degenerate wrap case.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    typedef struct packed {
        logic hs_high;
        logic vs_high;
        logic de_high;
        logic pclk_fall;
    } lcd_pol_t;

    function automatic logic drive_level(input logic active, input logic high_true);
        return active ? high_true : ~high_true;
    endfunction

endpackage

// File: rtl/lcd_tg_counter.sv
module lcd_tg_counter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   nxt_ext;

    always_comb begin
        nxt_ext = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
        wrap    = step && !clear && (nxt_ext >= {1'b0, limit});
        cnt_d   = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (step)
            cnt_d = wrap ? '0 : nxt_ext[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R1
    clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !wrap) |=> (cnt == $past(cnt) + 1'b1));

    // R10
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

endmodule

// File: rtl/lcd_tg_window.sv
module lcd_tg_window #(
    parameter int POS_W  = 18,
    parameter int SW_W   = 14,
    parameter int WAIT_W = 12,
    parameter int CNT_W  = 18
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [SW_W-1:0]   sync_w,
    input  logic [WAIT_W-1:0] wait_c,
    input  logic [CNT_W-1:0]  count,
    output logic              in_sync,
    output logic              in_win
);
    localparam int M1 = (POS_W > SW_W) ? POS_W : SW_W;
    localparam int M2 = (M1 > WAIT_W) ? M1 : WAIT_W;
    localparam int M3 = (M2 > CNT_W) ? M2 : CNT_W;
    localparam int EW = M3 + 1;

    logic [EW-1:0] pos_e, sw_e, wait_e, end_e;

    always_comb begin
        pos_e   = EW'(pos);
        sw_e    = EW'(sync_w);
        wait_e  = EW'(wait_c);
        end_e   = wait_e + EW'(count);
        in_sync = pos_e < sw_e;
        in_win  = (pos_e >= wait_e) && (pos_e < end_e);
    end

endmodule

// File: rtl/lcd_dotclk_timing.sv
module lcd_dotclk_timing
    import lcd_tg_pkg::*;
#(
    parameter int H_W     = 18,
    parameter int HSW_W   = 14,
    parameter int HWAIT_W = 12,
    parameter int V_W     = 18,
    parameter int VWAIT_W = 16,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_en,
    input  logic               run,
    input  logic [H_W-1:0]     line_period,
    input  logic [HSW_W-1:0]   hsync_width,
    input  logic [HWAIT_W-1:0] h_wait,
    input  logic [H_W-1:0]     h_pixels,
    input  logic [V_W-1:0]     frame_period,
    input  logic [V_W-1:0]     vsync_width,
    input  logic [VWAIT_W-1:0] v_wait,
    input  logic [VWAIT_W-1:0] v_lines,
    input  logic               hs_high,
    input  logic               vs_high,
    input  logic               de_high,
    input  logic               pclk_fall,
    input  logic [ADDR_W-1:0]  next_base,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic               pix_req,
    output logic [ADDR_W-1:0]  cur_base,
    output logic               pclk_invert
);
    typedef struct packed {
        logic              hsync;
        logic              vsync;
        logic              de;
        logic              req;
        logic              fetch;
        logic              pclk_inv;
        logic [ADDR_W-1:0] base;
    } tg_state_t;

    tg_state_t st_d, st_q;
    lcd_pol_t  pol;

    logic [H_W-1:0] h_cnt;
    logic [V_W-1:0] v_cnt;
    logic           h_wrap, v_wrap;
    logic           h_sync_act, h_win, v_sync_act, v_win;
    logic           frame_start, active;

    assign pol = '{hs_high: hs_high, vs_high: vs_high, de_high: de_high, pclk_fall: pclk_fall};

    lcd_tg_counter #(.W(H_W)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .clear(!sync_en), .step(sync_en),
        .limit(line_period), .cnt(h_cnt), .wrap(h_wrap)
    );

    lcd_tg_counter #(.W(V_W)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .clear(!sync_en), .step(h_wrap),
        .limit(frame_period), .cnt(v_cnt), .wrap(v_wrap)
    );

    lcd_tg_window #(.POS_W(H_W), .SW_W(HSW_W), .WAIT_W(HWAIT_W), .CNT_W(H_W)) u_hwin (
        .pos(h_cnt), .sync_w(hsync_width), .wait_c(h_wait), .count(h_pixels),
        .in_sync(h_sync_act), .in_win(h_win)
    );

    lcd_tg_window #(.POS_W(V_W), .SW_W(V_W), .WAIT_W(VWAIT_W), .CNT_W(VWAIT_W)) u_vwin (
        .pos(v_cnt), .sync_w(vsync_width), .wait_c(v_wait), .count(v_lines),
        .in_sync(v_sync_act), .in_win(v_win)
    );

    always_comb begin
        st_d        = st_q;
        frame_start = sync_en && (h_cnt == '0) && (v_cnt == '0);
        active      = h_win && v_win;
        if (!sync_en) begin
            st_d.hsync    = ~pol.hs_high;
            st_d.vsync    = ~pol.vs_high;
            st_d.de       = ~pol.de_high;
            st_d.req      = 1'b0;
            st_d.fetch    = 1'b0;
            st_d.pclk_inv = pol.pclk_fall;
        end else begin
            if (frame_start) begin
                st_d.base  = next_base;
                st_d.fetch = run;
            end
            st_d.hsync = drive_level(h_sync_act, pol.hs_high);
            st_d.vsync = drive_level(v_sync_act, pol.vs_high);
            st_d.de    = drive_level(active, pol.de_high);
            st_d.req   = active && st_d.fetch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hsync       = st_q.hsync;
    assign vsync       = st_q.vsync;
    assign de          = st_q.de;
    assign pix_req     = st_q.req;
    assign cur_base    = st_q.base;
    assign pclk_invert = st_q.pclk_inv;

    // R1
    off_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> (hsync == !$past(hs_high)) && (vsync == !$past(vs_high))
                     && (de == !$past(de_high)) && !pix_req);

    // R8
    req_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> (de == $past(de_high)));

    // R7
    base_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_base != $past(cur_base)) |-> $past(sync_en && (h_cnt == '0) && (v_cnt == '0)));

    // R9
    pclk_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_en) |-> (pclk_invert == $past(pclk_invert)));

endmodule

// File: tb/sim_lcd_dotclk_timing.sv
`timescale 1ns/1ps
module sim_lcd_dotclk_timing;
    localparam int H_W = 18, HSW_W = 8, HWAIT_W = 12, V_W = 18, VWAIT_W = 16, ADDR_W = 32;

    logic clk = 0, rst_n = 0;
    logic sync_en = 0, run = 0;
    logic [H_W-1:0] line_period = 0, h_pixels = 0;
    logic [HSW_W-1:0] hsync_width = 0;
    logic [HWAIT_W-1:0] h_wait = 0;
    logic [V_W-1:0] frame_period = 0, vsync_width = 0;
    logic [VWAIT_W-1:0] v_wait = 0, v_lines = 0;
    logic hs_high = 0, vs_high = 0, de_high = 0, pclk_fall = 0;
    logic [ADDR_W-1:0] next_base = 0;
    logic hsync, vsync, de, pix_req, pclk_invert;
    logic [ADDR_W-1:0] cur_base;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lcd_dotclk_timing #(.H_W(H_W), .HSW_W(HSW_W), .HWAIT_W(HWAIT_W), .V_W(V_W),
                        .VWAIT_W(VWAIT_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .run(run),
        .line_period(line_period), .hsync_width(hsync_width), .h_wait(h_wait),
        .h_pixels(h_pixels), .frame_period(frame_period), .vsync_width(vsync_width),
        .v_wait(v_wait), .v_lines(v_lines), .hs_high(hs_high), .vs_high(vs_high),
        .de_high(de_high), .pclk_fall(pclk_fall), .next_base(next_base),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
        .cur_base(cur_base), .pclk_invert(pclk_invert)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reference model of the requirements
    logic e_hs, e_vs, e_de, e_req, e_pclk, m_fetch;
    logic [ADDR_W-1:0] e_base;
    int m_h, m_v;

    function automatic logic lvl(input logic a, input logic hi);
        return a ? hi : ~hi;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            // R6
            e_hs = 0; e_vs = 0; e_de = 0; e_req = 0; e_pclk = 0; e_base = 0;
            m_fetch = 0; m_h = 0; m_v = 0;
        end else if (!sync_en) begin
            e_hs = ~hs_high; e_vs = ~vs_high; e_de = ~de_high; e_req = 0;
            e_pclk = pclk_fall; m_fetch = 0; m_h = 0; m_v = 0;
        end else begin
            bit fs, act;
            fs = (m_h == 0) && (m_v == 0);
            if (fs) begin e_base = next_base; m_fetch = run; end
            act = (m_h >= int'(h_wait)) && (m_h < int'(h_wait) + int'(h_pixels)) &&
                  (m_v >= int'(v_wait)) && (m_v < int'(v_wait) + int'(v_lines));
            e_hs  = lvl(m_h < int'(hsync_width), hs_high);
            e_vs  = lvl(m_v < int'(vsync_width), vs_high);
            e_de  = lvl(act, de_high);
            e_req = act && m_fetch;
            if (m_h + 1 >= int'(line_period)) begin
                m_h = 0;
                if (m_v + 1 >= int'(frame_period)) m_v = 0; else m_v++;
            end else m_h++;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 hsync", 64'(hsync), 64'(e_hs));
            chk("R3 vsync", 64'(vsync), 64'(e_vs));
            chk("R4 de", 64'(de), 64'(e_de));
            chk("R8 pix_req", 64'(pix_req), 64'(e_req));
            chk("R7 cur_base", 64'(cur_base), 64'(e_base));
            chk("R9 pclk_invert", 64'(pclk_invert), 64'(e_pclk));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        // R6: reset state
        chk("R6 reset hsync", 64'(hsync), 0);
        chk("R6 reset base", 64'(cur_base), 0);
        hs_high = 1; vs_high = 1; de_high = 1;
        rst_n = 1;
        wait_n(2);
        // R1: disabled -> inactive levels
        chk("R1 hsync idle", 64'(hsync), 0);
        chk("R1 vsync idle", 64'(vsync), 0);
        chk("R1 de idle", 64'(de), 0);

        // R11: full 8-bit hsync width
        line_period = 300; hsync_width = 255; frame_period = 2; sync_en = 1;
        begin
            int hi = 0;
            for (int i = 0; i < 300; i++) begin @(negedge clk); if (hsync) hi++; end
            chk("R11 hsync active clocks", 64'(hi), 255);
        end
        sync_en = 0; wait_n(2);

        // R5: active-low polarity while disabled
        hs_high = 0; vs_high = 0; de_high = 0; wait_n(1);
        chk("R5 low-true idle hsync", 64'(hsync), 1);
        chk("R5 low-true idle de", 64'(de), 1);

        // R10: zero line period, every clock a new line
        line_period = 0; frame_period = 3; hsync_width = 1; vsync_width = 1;
        hs_high = 1; vs_high = 1; sync_en = 1;
        wait_n(10);
        chk("R10 hsync always on", 64'(hsync), 1);
        sync_en = 0; wait_n(2);

        // R9: edge select frozen while running
        pclk_fall = 1; wait_n(1);
        chk("R9 captured while idle", 64'(pclk_invert), 1);
        line_period = 20; frame_period = 8; sync_en = 1; wait_n(1);
        pclk_fall = 0; wait_n(3);
        chk("R9 held while running", 64'(pclk_invert), 1);
        sync_en = 0; wait_n(2);

        // R8: run cleared mid-frame keeps requests to frame end
        line_period = 10; hsync_width = 1; h_wait = 2; h_pixels = 6;
        frame_period = 6; vsync_width = 1; v_wait = 1; v_lines = 4;
        de_high = 1; run = 1; next_base = 32'hA000; sync_en = 1;
        wait_n(1);
        chk("R7 first frame base", 64'(cur_base), 32'hA000);
        next_base = 32'hB000;
        wait_n(14); run = 0;
        wait_n(10);
        chk("R8 request continues after run cleared", 64'(pix_req), 1);
        chk("R7 base held mid-frame", 64'(cur_base), 32'hA000);
        wait_n(60);
        chk("R7 base swapped next frame", 64'(cur_base), 32'hB000);
        wait_n(20);
        chk("R8 no request in frame begun without run", 64'(pix_req), 0);
        sync_en = 0; wait_n(2);

        // Random configurations (model checks every cycle: R2 R3 R4 R5 R7 R8)
        for (int k = 0; k < 40; k++) begin
            line_period  = $urandom_range(24, 1);
            hsync_width  = $urandom_range(5, 0);
            h_wait       = $urandom_range(8, 0);
            h_pixels     = $urandom_range(15, 0);
            frame_period = $urandom_range(10, 1);
            vsync_width  = $urandom_range(3, 0);
            v_wait       = $urandom_range(4, 0);
            v_lines      = $urandom_range(6, 0);
            hs_high = $urandom; vs_high = $urandom; de_high = $urandom;
            pclk_fall = $urandom;
            wait_n(2);
            sync_en = 1;
            for (int c = 0; c < int'($urandom_range(600, 50)); c++) begin
                @(negedge clk);
                if ($urandom_range(36, 0) == 0) run = ~run;
                if ($urandom_range(9, 0) == 0) next_base = $urandom;
            end
            sync_en = 0;
        end
        wait_n(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule